// File: doc/BRIEF.md
# External Bus Controller with Per-Cycle Width Selection

This block turns memory requests from a 16-bit processor core into cycles on a multiplexed address/data bus with a 20-bit address. Each request carries an address, a read/write flag, an instruction-fetch flag, a byte/word size and write data. For each cycle the block puts the address on the shared lines and then uses the same lines for data. It drives an address strobe, the read and write strobes, a high-byte enable and an instruction-fetch indicator. It also controls the bus direction and the pin output enables. The block clock is the oscillator clock, and one bus state is two clocks.

Two configuration bits set the bus width: fixed 8-bit, fixed 16-bit, or chosen per cycle by a width pin that is sampled during the address phase. A word access on an 8-bit cycle is split into two byte cycles, low byte first. Programmed wait states and an optional slow-bus extra wait state stretch the data strobe. The address strobe can be a short latch pulse or an address-valid level. A fixed address window can be mapped to internal memory according to a strap that is latched during reset. An external master can take the bus with HOLD, and the block grants it only between cycles.

Top module: `ebc_dynwidth`

## Requirements
- R1: The width code {cfg_a,cfg_b} selects the cycle width. 10 gives 16-bit cycles. 01 gives 8-bit cycles. 11 takes the width from width_pin, sampled in the second address clock (1 = 16-bit, 0 = 8-bit). 00 is illegal: cfg_err is high and cycles run as 16-bit.
- R2: With cfg_adv = 0, bus_strobe is a one-clock high pulse in the first address clock of each cycle and is otherwise low. With cfg_adv = 1, bus_strobe is low from the first address clock up to the last data clock, and it is high in that last clock and while idle.
- R3: An access that decodes as internal causes no strobe, read, write or fetch-indicator activity. It pulses int_sel in the clock in which it is accepted, and req_done rises one clock later.
- R4: bus_inst is high in every clock of every external cycle of a fetch read, and low otherwise (including internal fetches).
- R5: The data phase lasts 2 + 2*(cfg_waits + cfg_slow) clocks. bus_rd_n (for a read) or bus_wr_n (for a write) is low for exactly that many clocks in each cycle.
- R6: ea_pin is latched while rst_n is low. If it was 1, addresses 0xF2000 through 0xF9FFF are internal; all other addresses, and every address when it was 0, are external.
- R7: breq is high whenever req_valid is high with an external address. When hold is high, the grant comes at the first cycle boundary. While hlda is high, bus_pins_oe and bus_ad_oe are low and no request is accepted. The grant ends in the clock after hold falls.
- R8: Each byte/word cycle takes two address clocks plus the data phase. A zero-wait cycle therefore spans 4 clocks from strobe to strobe. req_done is high for one clock, in the clock after the final data clock.
- R9: Word accesses ignore address bit 0. In an 8-bit cycle a word access runs at the even address and then at the odd address. Read data returns as {high,low}; a byte read returns {8'h00, byte}. A 16-bit word write drives req_wdata, and every other write drives its byte on both lanes.
- R10: bus_bhe_n is low during a cycle when the width code is not 01 and the cycle is either the first cycle of a word access or at an odd address. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ea_pin | input | 1 | Internal-region strap, latched in reset |
| cfg_a | input | 1 | Width code bit A |
| cfg_b | input | 1 | Width code bit B |
| cfg_slow | input | 1 | Adds one automatic wait state |
| cfg_adv | input | 1 | Strobe style: 0 latch pulse, 1 address-valid level |
| cfg_waits | input | WW | Programmed wait states |
| width_pin | input | 1 | Per-cycle width select in code 11 |
| req_valid | input | 1 | Request pending |
| req_ready | output | 1 | Request is taken at this clock edge |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = write |
| req_fetch | input | 1 | Instruction fetch |
| req_word | input | 1 | 1 = 16-bit access |
| req_wdata | input | 16 | Write data |
| int_sel | output | 1 | Accepted request targets internal memory |
| req_done | output | 1 | Transfer complete pulse |
| rsp_rdata | output | 16 | Read data, valid with req_done |
| bus_ad_out | output | 16 | Multiplexed address/data out |
| bus_ad_in | input | 16 | Multiplexed data in |
| bus_ad_oe | output | 1 | Drive enable for the address/data lines |
| bus_addr_hi | output | AW-16 | Upper address bits |
| bus_strobe | output | 1 | Address strobe (pulse or level) |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_bhe_n | output | 1 | High-byte enable, active low |
| bus_inst | output | 1 | Fetch-cycle indicator |
| bus_pins_oe | output | 1 | Enable for the address and strobe pins |
| breq | output | 1 | External cycle pending |
| hold | input | 1 | Bus hold request |
| hlda | output | 1 | Bus released |
| cfg_err | output | 1 | Illegal width code |

## Verification
A request accepted at an edge puts the bus in its first address clock right after that edge. req_done appears n*(4 + 2*(cfg_waits + cfg_slow)) + 1 falling edges later, where n is 1 or 2 byte/word cycles; an internal access takes exactly one. The bench drives inputs and samples outputs on the falling edge. It counts strobe, read, write and fetch-indicator clocks over that whole window, and it takes the address and lane values from the clocks where the bus direction shows the address or data phase, not from any fixed offset. The hold grant is checked as absent in every clock before completion and present in the completion clock.

// File: rtl/ebc_dynwidth.sv
module ebc_dynwidth #(
  parameter int AW = 20,
  parameter int WW = 3,
  parameter logic [AW-1:0] INT_LO = 20'hF2000,
  parameter logic [AW-1:0] INT_HI = 20'hF9FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ea_pin,
  input  logic          cfg_a,
  input  logic          cfg_b,
  input  logic          cfg_slow,
  input  logic          cfg_adv,
  input  logic [WW-1:0] cfg_waits,
  input  logic          width_pin,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_fetch,
  input  logic          req_word,
  input  logic [15:0]   req_wdata,
  output logic          int_sel,
  output logic          req_done,
  output logic [15:0]   rsp_rdata,
  output logic [15:0]   bus_ad_out,
  input  logic [15:0]   bus_ad_in,
  output logic          bus_ad_oe,
  output logic [AW-17:0] bus_addr_hi,
  output logic          bus_strobe,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic          bus_bhe_n,
  output logic          bus_inst,
  output logic          bus_pins_oe,
  output logic          breq,
  input  logic          hold,
  output logic          hlda,
  output logic          cfg_err
);
  localparam int CW = WW + 2;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_HELD} st_t;

  st_t           st;
  logic [CW-1:0] ph;
  logic [AW-1:0] a_addr;
  logic          a_wr, a_fetch, a_word;
  logic [15:0]   a_wdata;
  logic          hi_pend, wide, ea_q, done_q;
  logic [15:0]   rdata_q;

  logic [CW-1:0] dlen;
  logic          last, fix8, dyn, need_hi, req_int, accept, in_cyc;
  logic [AW-1:0] cur_addr;
  logic [7:0]    wbyte;

  assign dlen     = ((CW'(cfg_waits) + CW'(cfg_slow)) << 1) + CW'(2);
  assign last     = (st == S_DATA) && (ph == dlen - CW'(1));
  assign fix8     = !cfg_a && cfg_b;
  assign dyn      = cfg_a && cfg_b;
  assign cfg_err  = !cfg_a && !cfg_b;
  assign need_hi  = last && !wide && a_word && !hi_pend;
  assign req_int  = ea_q && (req_addr >= INT_LO) && (req_addr <= INT_HI);
  assign req_ready = !hold && ((st == S_IDLE) || (last && !need_hi && !req_int));
  assign accept   = req_ready && req_valid;
  assign int_sel  = accept && req_int;
  assign breq     = req_valid && !req_int;
  assign in_cyc   = (st == S_ADDR) || (st == S_DATA);
  assign cur_addr = hi_pend ? {a_addr[AW-1:1], 1'b1} :
                    a_word  ? {a_addr[AW-1:1], 1'b0} : a_addr;
  assign wbyte    = hi_pend ? a_wdata[15:8] : a_wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= '0;
      ea_q    <= ea_pin;
      a_addr  <= '0;
      a_wr    <= 1'b0;
      a_fetch <= 1'b0;
      a_word  <= 1'b0;
      a_wdata <= '0;
      hi_pend <= 1'b0;
      wide    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        a_addr  <= req_addr;
        a_wr    <= req_write;
        a_fetch <= req_fetch;
        a_word  <= req_word;
        a_wdata <= req_wdata;
        hi_pend <= 1'b0;
        ph      <= '0;
      end
      case (st)
        S_IDLE: begin
          if (hold)
            st <= S_HELD;
          else if (accept) begin
            if (req_int) done_q <= 1'b1;
            else         st <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (ph == CW'(1)) begin
            st   <= S_DATA;
            ph   <= '0;
            wide <= fix8 ? 1'b0 : (dyn ? width_pin : 1'b1);
          end else
            ph <= ph + CW'(1);
        end
        S_DATA: begin
          if (!last)
            ph <= ph + CW'(1);
          else begin
            if (!a_wr) begin
              if (wide)
                rdata_q <= a_word ? bus_ad_in
                                  : {8'h00, cur_addr[0] ? bus_ad_in[15:8] : bus_ad_in[7:0]};
              else if (hi_pend)
                rdata_q[15:8] <= bus_ad_in[7:0];
              else
                rdata_q <= {8'h00, bus_ad_in[7:0]};
            end
            if (need_hi) begin
              st      <= S_ADDR;
              ph      <= '0;
              hi_pend <= 1'b1;
            end else begin
              done_q <= 1'b1;
              if (hold)        st <= S_HELD;
              else if (accept) st <= S_ADDR;
              else begin
                st      <= S_IDLE;
                hi_pend <= 1'b0;
              end
            end
          end
        end
        default: begin
          if (!hold) st <= S_IDLE;
        end
      endcase
    end
  end

  assign req_done    = done_q;
  assign rsp_rdata   = rdata_q;
  assign hlda        = (st == S_HELD);
  assign bus_pins_oe = (st != S_HELD);
  assign bus_strobe  = cfg_adv ? !((st == S_ADDR) || (st == S_DATA && !last))
                               : ((st == S_ADDR) && (ph == '0));
  assign bus_rd_n    = !((st == S_DATA) && !a_wr);
  assign bus_wr_n    = !((st == S_DATA) && a_wr);
  assign bus_ad_oe   = (st == S_ADDR) || ((st == S_DATA) && a_wr);
  assign bus_ad_out  = (st == S_ADDR) ? cur_addr[15:0] :
                       (st == S_DATA) ? ((wide && a_word) ? a_wdata : {wbyte, wbyte}) : 16'h0000;
  assign bus_addr_hi = in_cyc ? cur_addr[AW-1:16] : '0;
  assign bus_bhe_n   = !(in_cyc && !fix8 && ((a_word && !hi_pend) || cur_addr[0]));
  assign bus_inst    = in_cyc && a_fetch && !a_wr;
endmodule

module ebc_dynwidth_chk (
  input logic clk,
  input logic rst_n,
  input logic hlda,
  input logic bus_pins_oe,
  input logic bus_ad_oe,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic bus_inst,
  input logic int_sel,
  input logic req_done
);
  a_r7_held_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_pins_oe && !bus_ad_oe));
  a_r7_grant_between: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> (bus_rd_n && bus_wr_n));
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));
  a_r5_strobe_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd_n) |=> !bus_rd_n);
  a_r4_inst_reads: assert property (@(posedge clk) disable iff (!rst_n)
    bus_inst |-> bus_wr_n);
  a_r3_internal_done: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |=> req_done);
endmodule

bind ebc_dynwidth ebc_dynwidth_chk u_chk (.*);

// File: tb/ebc_dynwidth_test.sv
module ebc_dynwidth_test;
  logic clk = 1'b0, rst_n = 1'b0, ea_pin = 1'b1;
  logic cfg_a = 1'b1, cfg_b = 1'b0, cfg_slow = 1'b0, cfg_adv = 1'b0, width_pin = 1'b1;
  logic [2:0] cfg_waits = 3'd0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_word = 1'b0, hold = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, int_sel, req_done, bus_ad_oe, bus_strobe, bus_rd_n, bus_wr_n;
  logic bus_bhe_n, bus_inst, bus_pins_oe, breq, hlda, cfg_err;
  logic [15:0] rsp_rdata, bus_ad_out, bus_ad_in;
  logic [3:0] bus_addr_hi;
  logic [19:0] la = '0;
  int nchk = 0, nfail = 0, cyc = 0;

  ebc_dynwidth uut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  assign bus_ad_in = {mb(la | 20'h1), mb(la)};
  always @(negedge clk)
    if (bus_pins_oe && bus_ad_oe && bus_rd_n && bus_wr_n) la <= {bus_addr_hi, bus_ad_out};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  int o_lat, o_hi, o_lo, o_rd, o_wr, o_inst;
  logic o_ready, o_int, o_breq, o_bhe, o_hlda_early, o_hlda_end, o_pins_end;
  logic [19:0] o_fa;
  logic [15:0] o_wfirst, o_wlast, o_rdata;

  task automatic xfer(input logic [19:0] a, input logic wr, fe, wd,
                      input logic [15:0] wdat, input int hold_at);
    logic got_a, got_w;
    req_addr = a; req_write = wr; req_fetch = fe; req_word = wd; req_wdata = wdat;
    req_valid = 1'b1;
    #1;
    o_ready = req_ready; o_int = int_sel; o_breq = breq;
    o_lat = 0; o_hi = 0; o_lo = 0; o_rd = 0; o_wr = 0; o_inst = 0;
    o_hlda_early = 1'b0; got_a = 1'b0; got_w = 1'b0;
    o_fa = '0; o_bhe = 1'b1; o_wfirst = '0; o_wlast = '0;
    for (int n = 1; n < 400 && o_lat == 0; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      if (hold_at != 0 && n == hold_at) hold = 1'b1;
      if (bus_strobe) o_hi++; else o_lo++;
      if (!bus_rd_n) o_rd++;
      if (!bus_inst == 1'b0) o_inst++;
      if (!bus_wr_n) begin
        if (!got_w) o_wfirst = bus_ad_out;
        got_w = 1'b1;
        o_wlast = bus_ad_out;
        o_wr++;
      end
      if (!got_a && bus_pins_oe && bus_ad_oe && bus_rd_n && bus_wr_n) begin
        got_a = 1'b1;
        o_fa = {bus_addr_hi, bus_ad_out};
        o_bhe = bus_bhe_n;
      end
      if (req_done) begin
        o_lat = n; o_rdata = rsp_rdata; o_hlda_end = hlda; o_pins_end = bus_pins_oe;
      end else if (hlda) o_hlda_early = 1'b1;
    end
  endtask

  task automatic do_reset(input logic ea);
    rst_n = 1'b0; ea_pin = ea;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset(1'b1);
    // reset state
    chk(bus_rd_n && bus_wr_n, "R2 reset rd/wr idle", {bus_rd_n, bus_wr_n}, 2'b11);
    chk(!bus_strobe, "R2 reset latch strobe low", bus_strobe, 0);
    chk(!req_done && !hlda && bus_pins_oe && !bus_ad_oe, "R7 reset hold/oe",
        {req_done, hlda, bus_pins_oe, bus_ad_oe}, 4'b0010);
    chk(!cfg_err, "R1 legal code no error", cfg_err, 0);

    for (int mode = 0; mode < 4; mode++)
      for (int w = 0; w < 3; w++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 7; k++) begin
            logic [19:0] a;
            logic wr, fe, wd, wide;
            logic [15:0] wdat, erd, ew1, ew2;
            logic [19:0] ea;
            int ncyc, dlen;
            cfg_a = (mode != 1); cfg_b = (mode != 0);
            width_pin = (mode == 3);
            cfg_waits = 3'(w); cfg_slow = s[0]; cfg_adv = k[0] ^ w[0];
            a = 20'h10000 + 20'(mode) * 20'h1000 + 20'(w) * 20'h100 + 20'(s) * 20'h40 + 20'(k) * 20'h4;
            if (k == 1 || k == 3) a = a + 20'h1;
            wr = (k == 3 || k == 4 || k == 6);
            fe = (k == 5);
            wd = (k == 2 || k == 4 || k == 5);
            wdat = {a[7:0] ^ 8'hA5, a[15:8]};
            wide = (mode == 0 || mode == 3);
            ncyc = (!wide && wd) ? 2 : 1;
            dlen = 2 + 2 * (w + s);
            ea = wd ? {a[19:1], 1'b0} : a;
            erd = wd ? {mb(ea | 20'h1), mb(ea)} : {8'h00, mb(a)};
            ew1 = (wide && wd) ? wdat : {wdat[7:0], wdat[7:0]};
            ew2 = (!wide && wd) ? {wdat[15:8], wdat[15:8]} : ew1;
            xfer(a, wr, fe, wd, wdat, 0);
            chk(o_ready && o_breq && !o_int, "R7 breq for external", {o_ready, o_breq, o_int}, 3'b110);
            chk(o_lat == ncyc * (2 + dlen) + 1, "R1 R8 width and completion time", o_lat, ncyc * (2 + dlen) + 1);
            if (cfg_adv)
              chk(o_lo == ncyc * (1 + dlen), "R2 address-valid low clocks", o_lo, ncyc * (1 + dlen));
            else
              chk(o_hi == ncyc, "R2 latch pulses", o_hi, ncyc);
            chk(o_rd == (wr ? 0 : ncyc * dlen), "R5 read strobe clocks", o_rd, wr ? 0 : ncyc * dlen);
            chk(o_wr == (wr ? ncyc * dlen : 0), "R5 write strobe clocks", o_wr, wr ? ncyc * dlen : 0);
            chk(o_inst == (fe ? ncyc * (2 + dlen) : 0), "R4 fetch indicator clocks", o_inst, fe ? ncyc * (2 + dlen) : 0);
            chk(o_fa == ea, "R9 first cycle address", o_fa, ea);
            chk(o_bhe == ((mode == 1) ? 1'b1 : !(wd || a[0])), "R10 high-byte enable", o_bhe,
                (mode == 1) ? 1'b1 : !(wd || a[0]));
            if (!wr) chk(o_rdata == erd, "R9 read data", o_rdata, erd);
            else begin
              chk(o_wfirst == ew1, "R9 first write lanes", o_wfirst, ew1);
              chk(o_wlast == ew2, "R9 last write lanes", o_wlast, ew2);
            end
          end

    // illegal width code
    cfg_a = 1'b0; cfg_b = 1'b0; cfg_waits = 3'd0; cfg_slow = 1'b0; cfg_adv = 1'b0;
    #1 chk(cfg_err, "R1 illegal code flagged", cfg_err, 1);
    xfer(20'h03456, 1'b0, 1'b0, 1'b1, 16'h0, 0);
    chk(o_lat == 5, "R1 illegal code runs 16-bit", o_lat, 5);
    cfg_a = 1'b1;

    // internal region decode with strap high
    xfer(20'hF4000, 1'b0, 1'b1, 1'b1, 16'h0, 0);
    chk(o_int && !o_breq, "R6 inside window internal", {o_int, o_breq}, 2'b10);
    chk(o_lat == 1, "R3 internal completes next clock", o_lat, 1);
    chk(o_hi == 0 && o_rd == 0 && o_inst == 0, "R3 R4 internal leaves bus idle", {o_hi[7:0], o_rd[7:0], o_inst[7:0]}, 0);
    xfer(20'hF9FFF, 1'b1, 1'b0, 1'b0, 16'h0, 0);
    chk(o_int && o_wr == 0, "R6 upper bound internal", {o_int, o_wr[7:0]}, 9'h100);
    xfer(20'hF1FFF, 1'b0, 1'b0, 1'b0, 16'h0, 0);
    chk(!o_int && o_breq && o_lat == 5, "R6 below window external", o_lat, 5);
    xfer(20'hFA000, 1'b0, 1'b0, 1'b0, 16'h0, 0);
    chk(!o_int && o_breq && o_lat == 5, "R6 above window external", o_lat, 5);

    // hold granted only at the boundary
    xfer(20'h04000, 1'b0, 1'b0, 1'b1, 16'h0, 2);
    chk(!o_hlda_early, "R7 no grant mid-cycle", o_hlda_early, 0);
    chk(o_hlda_end && !o_pins_end, "R7 grant at boundary with pins off", {o_hlda_end, o_pins_end}, 2'b10);
    req_addr = 20'h04100; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    chk(breq && !req_ready && hlda, "R7 pending during hold", {breq, req_ready, hlda}, 3'b101);
    hold = 1'b0;
    @(negedge clk);
    chk(!hlda && bus_pins_oe, "R7 release after hold drops", {hlda, bus_pins_oe}, 2'b01);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);

    // strap low: window goes external
    do_reset(1'b0);
    xfer(20'hF4000, 1'b0, 1'b1, 1'b0, 16'h0, 0);
    chk(!o_int && o_breq && o_lat == 5, "R6 strap low external", o_lat, 5);
    chk(o_inst == 4, "R4 external fetch indicator", o_inst, 4);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule